// File: doc/BRIEF.md
# Host-to-DSP Command Mailbox Bridge

This block lets a host on a simple register bus reach registers on a separate DSP-side bus. The host sees three words: a data word, a command word and a status word. For a DSP register write, the host loads the data word and then writes the command word. For a DSP register read, the host writes the command word and later collects the result from the data word. An interrupt acknowledge is started the same way as the other two commands.

Writing the command word is what starts the DSP-side access. The block raises a request and holds it, with kind, address and write data stable, until the DSP answers with a single-cycle acknowledge. The acknowledge may take any number of cycles. The host polls a ready flag in the status word. This flag drops in hardware as soon as a command is accepted and rises again once the DSP has finished.

A power-down input blocks new DSP accesses. While it is high, the status word does not carry valid data and reads as all ones. A command that cannot be accepted is dropped and leaves a sticky error flag, which the host clears by reading the status word.

Top module: `mbx_bridge`

## Requirements
- R1: After reset the ready flag is 1, the error flag is 0, the data word is 0 and `dsp_req` is low.
- R2: The host word offsets are fixed:
  - 0 is the data word (read/write).
  - 1 is the command word (write only, reads 0).
  - 2 is the status word: bit 0 is ready, bit 1 is error, all other bits 0.
  - 3 reads 0.
- R3: The command word layout is:
  - bits [9:8] give the type (00 register read, 01 register write, 10 interrupt acknowledge).
  - bits [7:0] give the DSP register address.
  An accepted command raises `dsp_req` on the next cycle, with `dsp_kind` equal to the type and `dsp_addr` equal to the address.
- R4: `dsp_wdata` carries the data word as it stood when the command was written. Host writes to the data word after that do not change it during the access.
- R5: An accepted command clears the ready flag from the next cycle. Ready returns to 1 in the cycle after the edge at which `dsp_ack` is sampled high with `dsp_req` high.
- R6: `dsp_req` and its kind, address and data stay constant until an acknowledge, however long that takes. An acknowledge while `dsp_req` is low has no effect.
- R7: For a read command, `dsp_rdata` is loaded into the data word on the acknowledge edge, the same edge at which ready returns. Write and interrupt acknowledge commands leave the data word unchanged.
- R8: A command written while ready is 0 starts no access and sets the sticky error flag.
- R9: A host read of the status word (outside power-down) clears the error flag after that read. The read itself still shows the flag.
- R10: A command with type 11 starts no access and sets the error flag.
- R11: While `dsp_pd` is 1:
  - the status word reads all ones;
  - a status read does not clear the error flag;
  - a command starts no access and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (status read side effect) |
| host_addr | input | 2 | Host word offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational on offset) |
| dsp_pd | input | 1 | DSP power-down |
| dsp_req | output | 1 | DSP access request, held until acknowledge |
| dsp_kind | output | 2 | Access type of the pending request |
| dsp_addr | output | 8 | DSP register address |
| dsp_wdata | output | 16 | Write data for the DSP |
| dsp_ack | input | 1 | One-cycle DSP completion |
| dsp_rdata | input | 16 | DSP read data, valid with `dsp_ack` |

## Verification
The two state elements that can go wrong unseen are the pending-access flag and the sticky error flag.

A pending flag stuck high shows as a ready bit that never returns. A pending flag that drops early shows as a ready bit rising before the acknowledge, or as `dsp_req` falling one cycle too soon. Both appear within one cycle of the acknowledge.

A wrong error flag shows at the next status read. A wrong latched address or data shows at the DSP port on the first cycle of the request. A misrouted read return shows in the data word on the cycle after the acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    K_RD   = 2'b00,
    K_WR   = 2'b01,
    K_IACK = 2'b10,
    K_BAD  = 2'b11
  } kind_e;

  localparam int unsigned HAW = 2;
  localparam logic [HAW-1:0] OFS_DATA = 2'd0;
  localparam logic [HAW-1:0] OFS_CMD  = 2'd1;
  localparam logic [HAW-1:0] OFS_STAT = 2'd2;

  function automatic logic kind_legal(input kind_e k);
    return k != K_BAD;
  endfunction

  // status bits: [1] error, [0] ready
  function automatic logic [1:0] stat_bits(input logic rdy, input logic err);
    return {err, rdy};
  endfunction
endpackage

// File: rtl/mbx_issue.sv
module mbx_issue
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  kind_e         cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          dsp_ack,
  input  logic [DW-1:0] dsp_rdata,
  output logic          dsp_req,
  output kind_e         dsp_kind,
  output logic [AW-1:0] dsp_addr,
  output logic [DW-1:0] dsp_wdata,
  output logic          ready,
  output logic          rd_done,
  output logic [DW-1:0] rd_value
);
  logic          req_q;
  kind_e         kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          finish;

  assign finish = req_q && dsp_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      kind_q  <= K_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      req_q   <= 1'b1;
      kind_q  <= cmd_kind;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end else if (finish) begin
      req_q <= 1'b0;
    end
  end

  assign dsp_req   = req_q;
  assign dsp_kind  = kind_q;
  assign dsp_addr  = addr_q;
  assign dsp_wdata = wdata_q;
  assign ready     = !req_q;
  assign rd_done   = finish && (kind_q == K_RD);
  assign rd_value  = dsp_rdata;

  // R6: request and its payload hold until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_req && !dsp_ack |=> dsp_req && $stable(dsp_addr) && $stable(dsp_kind) && $stable(dsp_wdata));
  // R8: no launch while an access is pending
  p_no_launch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !dsp_req);
  // R3: accepted command shows on the DSP port next cycle
  p_launch_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> dsp_req && dsp_addr == $past(cmd_addr) && dsp_kind == $past(cmd_kind));
  // R5: acknowledge ends the access
  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_req && dsp_ack |=> !dsp_req);
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           dsp_pd,
  input  logic           ready,
  input  logic           rd_done,
  input  logic [DW-1:0]  rd_value,
  output logic           launch,
  output kind_e          cmd_kind,
  output logic [AW-1:0]  cmd_addr,
  output logic [DW-1:0]  data_q
);
  localparam int unsigned KLO = AW;

  logic cmd_wr, cmd_ok, reject, stat_rd, err_q;

  assign cmd_wr   = host_wr && (host_addr == OFS_CMD);
  assign cmd_kind = kind_e'(host_wdata[KLO+1:KLO]);
  assign cmd_addr = host_wdata[AW-1:0];
  assign cmd_ok   = ready && !dsp_pd && kind_legal(cmd_kind);
  assign launch   = cmd_wr && cmd_ok;
  assign reject   = cmd_wr && !cmd_ok;
  assign stat_rd  = host_rd && (host_addr == OFS_STAT) && !dsp_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (reject)  err_q <= 1'b1;
    else if (stat_rd) err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   data_q <= '0;
    else if (rd_done)                             data_q <= rd_value;
    else if (host_wr && host_addr == OFS_DATA)    data_q <= host_wdata;
  end

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      OFS_DATA: host_rdata = data_q;
      OFS_STAT: host_rdata = dsp_pd ? '1 : DW'(stat_bits(ready, err_q));
      default:  host_rdata = '0;
    endcase
  end

  // R8 / R10 / R11: a refused command leaves the error flag set
  p_reject_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_q);
  // R11: power-down never starts an access
  p_pd_no_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_pd |-> !launch);
  // R9: a status read without a refusal clears the flag
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !reject |=> !err_q);
  // R7: read return lands in the data word
  p_rd_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> data_q == $past(rd_value));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [1:0]     host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           dsp_pd,
  output logic           dsp_req,
  output logic [1:0]     dsp_kind,
  output logic [AW-1:0]  dsp_addr,
  output logic [DW-1:0]  dsp_wdata,
  input  logic           dsp_ack,
  input  logic [DW-1:0]  dsp_rdata
);
  logic          launch, ready, rd_done;
  kind_e         cmd_kind, kind_out;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] data_q, rd_value;

  mbx_host_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .dsp_pd, .ready, .rd_done, .rd_value, .launch, .cmd_kind, .cmd_addr, .data_q
  );

  mbx_issue #(.DW(DW), .AW(AW)) u_issue (
    .clk, .rst_n, .launch, .cmd_kind, .cmd_addr, .cmd_wdata(data_q),
    .dsp_ack, .dsp_rdata, .dsp_req, .dsp_kind(kind_out), .dsp_addr, .dsp_wdata,
    .ready, .rd_done, .rd_value
  );

  assign dsp_kind = kind_out;

  // R5: ready is visible as 0 whenever a request is outstanding
  p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_req && !dsp_pd && host_addr == OFS_STAT |-> host_rdata[0] == 1'b0);
endmodule

// File: tb/test_mbx_bridge.sv
module test_mbx_bridge;
  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, host_rd = 0, dsp_pd = 0, dsp_ack = 0;
  logic [1:0]  host_addr = 0;
  logic [15:0] host_wdata = 0, dsp_rdata = 0, host_rdata, dsp_wdata;
  logic        dsp_req;
  logic [1:0]  dsp_kind;
  logic [7:0]  dsp_addr;

  int errs = 0, checks = 0, txn = 0, lat = 0, wcnt = 0;
  bit auto_ack = 1, done = 0;
  logic [1:0]  cap_kind;
  logic [7:0]  cap_addr;
  logic [15:0] cap_wdata;

  mbx_bridge i_mbx_bridge (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] dsp_val(input logic [7:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction

  function automatic logic [15:0] cmd_word(input logic [1:0] k, input logic [7:0] a);
    return {6'd0, k, a};
  endfunction

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    for (int i = 0; i < 60; i++) begin
      hread(2'd2, s);
      if (s[0]) return;
    end
    chk("R5 ready timeout", 16'h0, 16'h1);
  endtask

  task automatic manual_ack();
    @(negedge clk); dsp_rdata = dsp_val(dsp_addr); dsp_ack = 1;
    @(negedge clk); dsp_ack = 0;
  endtask

  // DSP responder
  initial forever begin
    @(negedge clk);
    if (auto_ack) begin
      if (dsp_ack) dsp_ack = 0;
      else if (dsp_req) begin
        if (wcnt >= lat) begin
          dsp_ack = 1; dsp_rdata = dsp_val(dsp_addr);
          cap_kind = dsp_kind; cap_addr = dsp_addr; cap_wdata = dsp_wdata;
          txn++; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d, model_data;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(2'd2, s); chk("R1 status", s, 16'h0001);
    peek(2'd0, s); chk("R1 data", s, 16'h0);
    chk("R1 req", {15'd0, dsp_req}, 16'h0);
    // R2 map
    hwrite(2'd0, 16'hBEEF);
    peek(2'd0, s); chk("R2 data rw", s, 16'hBEEF);
    peek(2'd1, s); chk("R2 cmd reads 0", s, 16'h0);
    peek(2'd3, s); chk("R2 ofs3 reads 0", s, 16'h0);

    // R3/R4/R6/R8/R9: held request, staging, busy refusal
    auto_ack = 0;
    hwrite(2'd0, 16'h1357);
    hwrite(2'd1, cmd_word(2'b01, 8'h3C));
    chk("R3 req", {15'd0, dsp_req}, 16'h1);
    chk("R3 kind", {14'd0, dsp_kind}, 16'h1);
    chk("R3 addr", {8'd0, dsp_addr}, 16'h003C);
    hwrite(2'd0, 16'h9999);
    chk("R4 wdata staged", dsp_wdata, 16'h1357);
    hwrite(2'd1, cmd_word(2'b00, 8'h11));
    chk("R8 busy cmd ignored addr", {8'd0, dsp_addr}, 16'h003C);
    repeat (5) @(negedge clk);
    chk("R6 req held", {15'd0, dsp_req}, 16'h1);
    hread(2'd2, s); chk("R8 err set, R5 not ready", s, 16'h0002);
    hread(2'd2, s); chk("R9 err cleared", s, 16'h0000);
    manual_ack();
    chk("R5 req dropped", {15'd0, dsp_req}, 16'h0);
    peek(2'd2, s); chk("R5 ready back", s, 16'h0001);
    peek(2'd0, s); chk("R7 write keeps data", s, 16'h9999);

    // R6 stray ack ignored
    dsp_rdata = 16'h4242; dsp_ack = 1; @(negedge clk); dsp_ack = 0;
    peek(2'd0, s); chk("R6 stray ack data", s, 16'h9999);
    peek(2'd2, s); chk("R6 stray ack status", s, 16'h0001);

    // R7 read return timing
    hwrite(2'd1, cmd_word(2'b00, 8'h5E));
    peek(2'd2, s); chk("R5 ready low", s, 16'h0000);
    manual_ack();
    peek(2'd2, s); chk("R7 ready same edge", s, 16'h0001);
    peek(2'd0, s); chk("R7 read data", s, dsp_val(8'h5E));

    // R10 illegal type
    hwrite(2'd1, cmd_word(2'b11, 8'h01));
    chk("R10 no req", {15'd0, dsp_req}, 16'h0);
    hread(2'd2, s); chk("R10 err", s, 16'h0003);

    // R11 power-down
    dsp_pd = 1;
    hread(2'd2, s); chk("R11 status ones", s, 16'hFFFF);
    hwrite(2'd1, cmd_word(2'b01, 8'h22));
    repeat (3) @(negedge clk);
    chk("R11 no access", {15'd0, dsp_req}, 16'h0);
    hread(2'd2, s);
    dsp_pd = 0;
    peek(2'd2, s); chk("R11 err kept", s, 16'h0003);
    hread(2'd2, s);

    // random traffic
    auto_ack = 1;
    peek(2'd0, model_data);
    for (int n = 0; n < 300; n++) begin
      logic [1:0] k; logic [7:0] a; logic [15:0] wd; int t0;
      k = 2'($urandom_range(0, 2)); a = 8'($urandom); wd = 16'($urandom);
      lat = $urandom_range(0, 6);
      hwrite(2'd0, wd); model_data = wd;
      t0 = txn;
      hwrite(2'd1, cmd_word(k, a));
      wait_ready();
      chk("R5 one access", 16'(txn - t0), 16'h1);
      chk("R3 kind rand", {14'd0, cap_kind}, {14'd0, k});
      chk("R3 addr rand", {8'd0, cap_addr}, {8'd0, a});
      if (k == 2'b01) chk("R4 wdata rand", cap_wdata, wd);
      if (k == 2'b00) model_data = dsp_val(a);
      peek(2'd0, d); chk("R7 data rand", d, model_data);
      peek(2'd2, s); chk("R8 no err rand", s, 16'h0001);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule